// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem control lines (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them as one 8-bit status byte. The upper nibble gives the present asserted state of each line. The lower nibble holds sticky change flags that latch an event until the register is read. The carrier-detect, data-set-ready and clear-to-send flags latch on any transition of their line. The ring flag latches only when the ring line goes from logic 0 back to logic 1, which is the trailing edge of a ring pulse.

Each raw line passes through a two-flop synchronizer. Edge detection compares each synchronized sample with the one taken a cycle earlier. Every change flag is held by a small two-state machine:

- FLAG_CLEAR: no event pending. The transition CLEAR_TO_SET is taken on a qualifying edge.
- FLAG_SET: an event is pending. The transition SET_TO_CLEAR is taken on a read strobe in a cycle with no new qualifying edge. HOLD_ON_EVENT keeps the state in FLAG_SET when a read and a new edge meet in the same cycle, so that event is not lost.

An interrupt request is raised while any flag is set and the interrupt enable input is high.

Top module: `modem_status_monitor`

## Requirements
- R1: Bit 0 of `status` becomes 1 when the synchronized clear-to-send line changes in either direction. It is visible three clock edges after the input changes.
- R2: Bit 1 becomes 1 when the synchronized data-set-ready line changes in either direction.
- R3: Bit 2 becomes 1 only when `ri_n` goes from 0 to 1. A 1-to-0 change of `ri_n` leaves bit 2 unchanged.
- R4: Bit 3 becomes 1 when the synchronized carrier-detect line changes in either direction.
- R5: A set change bit stays 1 until a cycle in which `rd_stb` is high. It is 0 after that clock edge unless a new qualifying edge for that line occurs in the same cycle, in which case it stays 1. All change bits are 0 after reset.
- R6: `irq` equals `irq_en` AND the OR of `status[3:0]`.
- R7: `status[7:4]` report the inverted synchronized levels, with bit 7 = carrier detect, bit 6 = ring, bit 5 = data-set-ready and bit 4 = clear-to-send. They are 0 after reset and follow an input change two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Raw clear-to-send, active low |
| dsr_n | input | 1 | Raw data-set-ready, active low |
| ri_n | input | 1 | Raw ring indicator, active low |
| dcd_n | input | 1 | Raw carrier detect, active low |
| rd_stb | input | 1 | Status register read strobe, one cycle |
| irq_en | input | 1 | Modem-status interrupt enable |
| status | output | 8 | Levels [7:4], change flags [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
Each line is toggled first toward assertion and then back, with a read between the two toggles. This separates any-edge detection from single-edge detection and exposes a wrong bit position. The ring line shows that its asserting edge sets nothing while its releasing edge does. A toggle timed to land in the cycle of a read tells a lost event apart from a held one. Several lines changing at once, with the enable both low and high, check that the flags stay independent and that the interrupt is gated.

// File: rtl/msm_pkg.sv
package msm_pkg;
    localparam int LINES = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_t;
endpackage

// File: rtl/msm_sync.sv
module msm_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/msm_flag_fsm.sv
module msm_flag_fsm
    import msm_pkg::*;
#(
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rd,
    output logic flag
);
    logic        prev_q;
    logic        edge_hit;
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    generate
        if (RISE_ONLY) begin : g_rise
            assign edge_hit = lvl & ~prev_q;
        end else begin : g_any
            assign edge_hit = lvl ^ prev_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (edge_hit)        state_d = FLAG_SET;   // CLEAR_TO_SET
            FLAG_SET:   if (rd && !edge_hit) state_d = FLAG_CLEAR; // SET_TO_CLEAR, else HOLD_ON_EVENT
            default:                         state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
    import msm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] status,
    output logic       irq
);
    localparam int STAT_W = 2 * LINES;

    logic [LINES-1:0]  raw_n;
    logic [LINES-1:0]  sync_n;
    logic [LINES-1:0]  flags;
    logic [STAT_W-1:0] stat_w;

    assign raw_n[IDX_CTS] = cts_n;
    assign raw_n[IDX_DSR] = dsr_n;
    assign raw_n[IDX_RI]  = ri_n;
    assign raw_n[IDX_DCD] = dcd_n;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            msm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (raw_n[i]),
                .q    (sync_n[i])
            );
            msm_flag_fsm #(.RISE_ONLY(i == IDX_RI)) u_flag (
                .clk  (clk),
                .rst_n(rst_n),
                .lvl  (sync_n[i]),
                .rd   (rd_stb),
                .flag (flags[i])
            );
        end
    endgenerate

    assign stat_w = {~sync_n, flags};
    assign status = stat_w;
    assign irq    = irq_en & (|flags);
endmodule

// File: rtl/msm_chk.sv
module msm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       irq_en,
    input logic [7:0] status,
    input logic       irq
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_en && (status[3:0] != 4'b0))); // R6
    AST_CTS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[4]) |=> status[0]); // R1
    AST_DSR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[5]) |=> status[1]); // R2
    AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |=> status[2]); // R3
    AST_RI_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[6]) && !status[2]) |=> !status[2]); // R3
    AST_DCD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[7]) |=> status[3]); // R4
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((status[3:0] & $past(status[3:0])) == $past(status[3:0]))); // R5
    AST_CTS_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && $stable(status[4])) |=> !status[0]); // R5
endmodule

bind modem_status_monitor msm_chk u_chk (.*);

// File: tb/modem_status_monitor_tb.sv
module modem_status_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       rd_stb = 1'b0, irq_en = 1'b0;
    logic [7:0] status;
    logic       irq;
    int         n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    modem_status_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .rd_stb(rd_stb), .irq_en(irq_en), .status(status), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read();
        rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        check("R5 reset flags", {4'b0, status[3:0]}, 8'h00);
        check("R7 reset levels", status, 8'h00);
        check("R6 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_any_edge(input int idx);
        string rq;
        rq = (idx == 0) ? "R1" : (idx == 1) ? "R2" : "R4";
        if (idx == 0) cts_n = 1'b0; else if (idx == 1) dsr_n = 1'b0; else dcd_n = 1'b0;
        tick(2);
        check({"R7 level ", rq}, status, 8'h10 << ((idx == 3) ? 3 : idx));
        tick(1);
        check({rq, " assert edge"}, status, (8'h10 << ((idx == 3) ? 3 : idx)) | (8'h01 << idx));
        do_read();
        check({"R5 read clears ", rq}, status, 8'h10 << ((idx == 3) ? 3 : idx));
        if (idx == 0) cts_n = 1'b1; else if (idx == 1) dsr_n = 1'b1; else dcd_n = 1'b1;
        tick(3);
        check({rq, " release edge"}, status, 8'h01 << idx);
        do_read();
        check({"R5 cleared ", rq}, status, 8'h00);
    endtask

    task automatic t_ring();
        ri_n = 1'b0; tick(4);
        check("R3 leading edge ignored", status, 8'h40);
        ri_n = 1'b1; tick(3);
        check("R3 trailing edge sets", status, 8'h04);
        do_read();
        check("R5 ring cleared", status, 8'h00);
    endtask

    task automatic t_read_collide();
        cts_n = 1'b0; tick(3);
        cts_n = 1'b1; tick(2);
        do_read();
        check("R5 event at read held", status, 8'h01);
        tick(2);
        do_read();
        check("R5 later read clears", status, 8'h00);
        dsr_n = 1'b0; tick(2);
        do_read();
        check("R5 first event at read kept", status, 8'h22);
        do_read();
        dsr_n = 1'b1; tick(3); do_read();
    endtask

    task automatic t_multi_irq();
        irq_en = 1'b0;
        cts_n = 1'b0; dcd_n = 1'b0; tick(3);
        check("R1 R4 multi", status, 8'h99);
        check("R6 irq gated off", {7'b0, irq}, 8'h00);
        irq_en = 1'b1; tick(1);
        check("R6 irq on", {7'b0, irq}, 8'h01);
        do_read();
        check("R6 irq after read", {7'b0, irq}, 8'h00);
        cts_n = 1'b1; dcd_n = 1'b1; tick(3);
        check("R6 irq release", {7'b0, irq}, 8'h01);
        do_read();
        check("R5 final clear", status, 8'h00);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_any_edge(0);
        t_any_edge(1);
        t_any_edge(3);
        t_ring();
        t_read_collide();
        t_multi_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #50000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule